// File: doc/BRIEF.md
# Multi-Level Sleep State Controller

This block sequences the power state of one processor core. From the running state it can take the core into one of three sleep depths, each one stacking extra power-saving steps on top of the shallower one, and bring it back again. The shallowest depth stops the core clock, flushes the L1 cache and then power-gates the L1. The middle depth also switches the PLL off. The deepest depth also power-gates the core and the remaining caches. A deeper sleep saves more power but takes longer to leave, so the block holds back its wake-up completion pulse until a per-depth latency, counted in clock cycles, has passed.

Every gating control changes on its own clock edge, and consecutive changes are spaced by a programmable step delay. This stops the supply current from jumping when the core is put to sleep or woken. The L1 flush uses a request/acknowledge handshake, and the cache is never gated before the acknowledge arrives. A wake that arrives during the flush cancels the entry once the flush has completed. An over-temperature or over-issue-rate flag forces the low-frequency operating point. Full speed is allowed again only after both flags have stayed clear for a programmable hysteresis count. A plain low-frequency request input also selects the reduced point. All pins are plain control and status levels or pulses, so no handshake with back-pressure applies.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After reset: clk_en=1, pll_en=1, l1_flush_req=0, l1_pg_en=0, core_pg_en=0, op_sel=0, wake_done=0, err=0, pm_state=0.
- R2: A sleep_req pulse in the running state with sleep_depth 1, 2 or 3 ends in sleep with these outputs. Every depth has clk_en=0 and l1_pg_en=1. pll_en is 1 only for depth 1. core_pg_en is 1 only for depth 3. pm_state is 2, 3 or 4 for depth 1, 2 or 3.
- R3: During entry, l1_flush_req stays high until flush_ack is seen. l1_pg_en rises only after a cycle with l1_flush_req and flush_ack both high.
- R4: Within an entry or exit sequence, no two of clk_en, pll_en, l1_pg_en and core_pg_en change on the same edge. Consecutive changes are at least step_delay+1 cycles apart.
- R5: On exit the order is reversed: core_pg_en falls before l1_pg_en falls, both are low before pll_en rises, and clk_en rises only on an edge where pll_lock was high.
- R6: When the wake input is sampled in sleep at depth d, wake_done pulses high for one cycle exactly LAT_d cycles after that edge, provided the restore sequence has already finished. The defaults are 125, 2500 and 12500 cycles for depths 1, 2 and 3. After the pulse the block is running with every gate restored.
- R7: If wake is high at any point during the flush handshake, the flush completes, l1_pg_en never rises, and the block returns to running with clk_en=1 and a wake_done pulse.
- R8: A sleep_req is illegal if sleep_depth is 0 or the block is not in the running state. An illegal sleep_req changes no output other than err, which becomes 1 and stays 1 until reset.
- R9: temp_hot or rate_hot high on an edge makes op_sel=1 (low-frequency point) from that edge onward. pm_state then reads 1 in the running state.
- R10: After the last edge with an over-limit flag high, op_sel (with lf_req low) stays 1 for hyst_cnt-1 edges and returns to 0 on edge hyst_cnt, counting edges with both flags low. A hyst_cnt of 0 acts as 1.
- R11: lf_req high selects op_sel=1 and pm_state=1 while running, whatever the throttle state.
- R12: pm_state reads 5 while entering sleep and 6 while waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| sleep_depth | input | 2 | Requested depth, 1 shallow to 3 deep |
| wake | input | 1 | Wake event |
| lf_req | input | 1 | Request for the low-frequency point |
| temp_hot | input | 1 | Die temperature over limit |
| rate_hot | input | 1 | Issue rate over limit |
| flush_ack | input | 1 | L1 flush finished |
| pll_lock | input | 1 | PLL locked |
| step_delay | input | STEP_W | Extra cycles between gating changes |
| hyst_cnt | input | HYST_W | Clear cycles needed to leave throttle |
| clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| l1_flush_req | output | 1 | L1 flush request |
| l1_pg_en | output | 1 | L1 power gate (1 = off) |
| core_pg_en | output | 1 | Core and cache power gate (1 = off) |
| op_sel | output | 1 | 0 full speed, 1 reduced frequency and voltage |
| pm_state | output | 3 | 0 full, 1 low freq, 2..4 sleep depth 1..3, 5 entering, 6 waking |
| wake_done | output | 1 | One-cycle pulse when wake-up is complete |
| err | output | 1 | Sticky illegal-request flag |

## Verification
The bench targets the points where sequencing usually breaks. One is a wake that lands while the flush is still waiting for its acknowledge: a faulty design would gate the L1 anyway or hang in the handshake. Another is a sleep request made while the block is already asleep: a faulty design would jump straight to a shallower state without restoring power. The wake-done pulse is timed to the exact cycle for every depth, so a latency counter that is off by one, or that is loaded with the wrong depth, is caught. The bench also follows throttle hysteresis to the exact edge and restarts it when a flag comes back, so a counter that is not cleared by a new over-limit event fails.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [3:0] {
    PH_RUN, PH_FLUSH, PH_L1, PH_PLL, PH_CORE, PH_SLEEP,
    PH_XCORE, PH_XL1, PH_XPLL, PH_XCLK, PH_XDONE
  } phase_t;

  localparam logic [2:0] ST_FULL  = 3'd0;
  localparam logic [2:0] ST_LOW   = 3'd1;
  localparam logic [2:0] ST_ENTER = 3'd5;
  localparam logic [2:0] ST_WAKE  = 3'd6;
endpackage

// File: rtl/pm_throttle.sv
module pm_throttle #(
  parameter int HYST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hot,
  input  logic [HYST_W-1:0] hyst_cnt,
  output logic              throttle
);
  logic [HYST_W-1:0] clear_cnt;
  logic [HYST_W:0]   clear_nxt;

  always_comb clear_nxt = {1'b0, clear_cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      throttle  <= 1'b0;
      clear_cnt <= '0;
    end else if (hot) begin
      throttle  <= 1'b1;
      clear_cnt <= '0;
    end else if (throttle) begin
      if (clear_nxt >= {1'b0, hyst_cnt}) begin
        throttle  <= 1'b0;
        clear_cnt <= '0;
      end else begin
        clear_cnt <= clear_nxt[HYST_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pm_lat_timer.sv
module pm_lat_timer #(
  parameter int LAT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             expired
);
  logic [LAT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int LAT_W  = 14,
  parameter int LAT1   = 125,
  parameter int LAT2   = 2500,
  parameter int LAT3   = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [1:0]        sleep_depth,
  input  logic              wake,
  input  logic              flush_ack,
  input  logic              pll_lock,
  input  logic [STEP_W-1:0] step_delay,
  input  logic              lat_expired,
  output logic              lat_load,
  output logic [LAT_W-1:0]  lat_val,
  output phase_t            phase,
  output logic [1:0]        depth_q,
  output logic              clk_en,
  output logic              pll_en,
  output logic              flush_req,
  output logic              l1_pg,
  output logic              core_pg,
  output logic              done,
  output logic              err
);
  logic [STEP_W-1:0] timer;
  logic              wake_seen;
  logic              wake_any;
  logic              step_due;

  assign wake_any = wake | wake_seen;
  assign step_due = (timer == '0);
  assign lat_load = (phase == PH_SLEEP) && wake_any;

  always_comb begin
    case (depth_q)
      2'd3:    lat_val = LAT_W'(LAT3 - 1);
      2'd2:    lat_val = LAT_W'(LAT2 - 1);
      default: lat_val = LAT_W'(LAT1 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RUN;
      depth_q   <= 2'd0;
      clk_en    <= 1'b1;
      pll_en    <= 1'b1;
      flush_req <= 1'b0;
      l1_pg     <= 1'b0;
      core_pg   <= 1'b0;
      timer     <= '0;
      wake_seen <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sleep_req && (phase != PH_RUN || sleep_depth == 2'd0)) err <= 1'b1;
      if (wake && phase != PH_RUN) wake_seen <= 1'b1;
      if (phase != PH_RUN && phase != PH_SLEEP && !step_due) timer <= timer - 1'b1;
      case (phase)
        PH_RUN: if (sleep_req && sleep_depth != 2'd0) begin
          clk_en    <= 1'b0;
          depth_q   <= sleep_depth;
          wake_seen <= 1'b0;
          timer     <= step_delay;
          phase     <= PH_FLUSH;
        end
        PH_FLUSH: if (step_due) begin
          if (!flush_req) flush_req <= 1'b1;
          else if (flush_ack) begin
            flush_req <= 1'b0;
            timer     <= step_delay;
            if (wake_any) begin
              wake_seen <= 1'b0;
              phase     <= PH_XCLK;
            end else begin
              phase <= PH_L1;
            end
          end
        end
        PH_L1: if (step_due) begin
          l1_pg <= 1'b1;
          timer <= step_delay;
          phase <= (depth_q == 2'd1) ? PH_SLEEP : PH_PLL;
        end
        PH_PLL: if (step_due) begin
          pll_en <= 1'b0;
          timer  <= step_delay;
          phase  <= (depth_q == 2'd3) ? PH_CORE : PH_SLEEP;
        end
        PH_CORE: if (step_due) begin
          core_pg <= 1'b1;
          timer   <= step_delay;
          phase   <= PH_SLEEP;
        end
        PH_SLEEP: if (wake_any) begin
          wake_seen <= 1'b0;
          timer     <= step_delay;
          phase     <= PH_XCORE;
        end
        PH_XCORE: if (step_due) begin
          if (core_pg) begin
            core_pg <= 1'b0;
            timer   <= step_delay;
          end
          phase <= PH_XL1;
        end
        PH_XL1: if (step_due) begin
          if (l1_pg) begin
            l1_pg <= 1'b0;
            timer <= step_delay;
          end
          phase <= PH_XPLL;
        end
        PH_XPLL: if (step_due) begin
          if (!pll_en) begin
            pll_en <= 1'b1;
            timer  <= step_delay;
          end
          phase <= PH_XCLK;
        end
        PH_XCLK: if (step_due && pll_lock) begin
          clk_en <= 1'b1;
          phase  <= PH_XDONE;
        end
        PH_XDONE: if (lat_expired) begin
          done  <= 1'b1;
          phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
  import pm_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int HYST_W = 8,
  parameter int LAT1   = 125,
  parameter int LAT2   = 2500,
  parameter int LAT3   = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [1:0]        sleep_depth,
  input  logic              wake,
  input  logic              lf_req,
  input  logic              temp_hot,
  input  logic              rate_hot,
  input  logic              flush_ack,
  input  logic              pll_lock,
  input  logic [STEP_W-1:0] step_delay,
  input  logic [HYST_W-1:0] hyst_cnt,
  output logic              clk_en,
  output logic              pll_en,
  output logic              l1_flush_req,
  output logic              l1_pg_en,
  output logic              core_pg_en,
  output logic              op_sel,
  output logic [2:0]        pm_state,
  output logic              wake_done,
  output logic              err
);
  localparam int LAT_MAX = (LAT3 > LAT2) ? ((LAT3 > LAT1) ? LAT3 : LAT1)
                                         : ((LAT2 > LAT1) ? LAT2 : LAT1);
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  phase_t           phase;
  logic [1:0]       depth_q;
  logic             throttle_q;
  logic             lat_load;
  logic             lat_expired;
  logic [LAT_W-1:0] lat_val;

  pm_throttle #(.HYST_W(HYST_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .hot(temp_hot | rate_hot),
    .hyst_cnt(hyst_cnt), .throttle(throttle_q)
  );

  pm_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(lat_load),
    .load_val(lat_val), .expired(lat_expired)
  );

  pm_seq #(
    .STEP_W(STEP_W), .LAT_W(LAT_W), .LAT1(LAT1), .LAT2(LAT2), .LAT3(LAT3)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_depth(sleep_depth),
    .wake(wake), .flush_ack(flush_ack), .pll_lock(pll_lock),
    .step_delay(step_delay), .lat_expired(lat_expired), .lat_load(lat_load),
    .lat_val(lat_val), .phase(phase), .depth_q(depth_q), .clk_en(clk_en),
    .pll_en(pll_en), .flush_req(l1_flush_req), .l1_pg(l1_pg_en),
    .core_pg(core_pg_en), .done(wake_done), .err(err)
  );

  assign op_sel = throttle_q | lf_req;

  always_comb begin
    case (phase)
      PH_RUN:                      pm_state = op_sel ? ST_LOW : ST_FULL;
      PH_SLEEP:                    pm_state = {1'b0, depth_q} + 3'd1;
      PH_FLUSH, PH_L1, PH_PLL,
      PH_CORE:                     pm_state = ST_ENTER;
      default:                     pm_state = ST_WAKE;
    endcase
  end
endmodule

// File: rtl/pm_sleep_ctrl_chk.sv
module pm_sleep_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic temp_hot,
  input logic rate_hot,
  input logic flush_ack,
  input logic pll_lock,
  input logic clk_en,
  input logic pll_en,
  input logic l1_flush_req,
  input logic l1_pg_en,
  input logic core_pg_en,
  input logic op_sel,
  input logic throttle_q,
  input logic wake_done,
  input logic err
);
  logic ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ack_seen <= 1'b0;
    else if (l1_flush_req && flush_ack)  ack_seen <= 1'b1;
    else if (clk_en)                     ack_seen <= 1'b0;
  end

  a_r3_gate_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l1_pg_en) |-> ack_seen);

  a_r4_one_gate_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({clk_en, pll_en, l1_pg_en, core_pg_en} ^
               $past({clk_en, pll_en, l1_pg_en, core_pg_en})) <= 1);

  a_r2_deep_is_cumulative: assert property (@(posedge clk) disable iff (!rst_n)
    core_pg_en |-> (l1_pg_en && !pll_en && !clk_en));

  a_r5_clock_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !clk_en);

  a_r5_clock_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(pll_lock));

  a_r9_throttle_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_hot || rate_hot) |=> op_sel);

  a_r10_no_release_when_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(throttle_q) |-> !$past(temp_hot || rate_hot));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);
endmodule

bind pm_sleep_ctrl pm_sleep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .rate_hot(rate_hot),
  .flush_ack(flush_ack), .pll_lock(pll_lock), .clk_en(clk_en), .pll_en(pll_en),
  .l1_flush_req(l1_flush_req), .l1_pg_en(l1_pg_en), .core_pg_en(core_pg_en),
  .op_sel(op_sel), .throttle_q(throttle_q), .wake_done(wake_done), .err(err)
);

// File: tb/tb_pm_sleep_ctrl.sv
module tb_pm_sleep_ctrl;
  localparam int L1C = 125;
  localparam int L2C = 2500;
  localparam int L3C = 12500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake = 1'b0, lf_req = 1'b0;
  logic temp_hot = 1'b0, rate_hot = 1'b0;
  logic [1:0] sleep_depth = 2'd0;
  logic [3:0] step_delay = 4'd0;
  logic [7:0] hyst_cnt = 8'd1;
  logic flush_ack, pll_lock;
  logic clk_en, pll_en, l1_flush_req, l1_pg_en, core_pg_en, op_sel, wake_done, err;
  logic [2:0] pm_state;

  int n_chk = 0, n_fail = 0, ack_lat = 0, ack_cnt;
  logic [2:0] lock_sr;

  always #4 clk = ~clk;

  pm_sleep_ctrl #(.LAT1(L1C), .LAT2(L2C), .LAT3(L3C)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_depth(sleep_depth),
    .wake(wake), .lf_req(lf_req), .temp_hot(temp_hot), .rate_hot(rate_hot),
    .flush_ack(flush_ack), .pll_lock(pll_lock), .step_delay(step_delay),
    .hyst_cnt(hyst_cnt), .clk_en(clk_en), .pll_en(pll_en),
    .l1_flush_req(l1_flush_req), .l1_pg_en(l1_pg_en), .core_pg_en(core_pg_en),
    .op_sel(op_sel), .pm_state(pm_state), .wake_done(wake_done), .err(err)
  );

  // cache and PLL stand-ins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_ack <= 1'b0; ack_cnt <= 0; lock_sr <= '0;
    end else begin
      if (l1_flush_req && !flush_ack) begin
        if (ack_cnt >= ack_lat) flush_ack <= 1'b1;
        else ack_cnt <= ack_cnt + 1;
      end else if (!l1_flush_req) begin
        flush_ack <= 1'b0; ack_cnt <= 0;
      end
      lock_sr <= {lock_sr[1:0], pll_en};
    end
  end
  assign pll_lock = pll_en & lock_sr[2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int d);
    return (d == 3) ? L3C : (d == 2) ? L2C : L1C;
  endfunction

  // sequencing monitor: R3, R4, R5
  logic [3:0] g_prev = 4'b1100;
  logic lock_prev = 1'b0, ack_seen = 1'b0, have_last = 1'b0, l1_seen = 1'b0;
  int cyc = 0, last_chg = 0;
  always @(negedge clk) begin
    logic [3:0] g;
    g = {clk_en, pll_en, l1_pg_en, core_pg_en};
    if (!rst_n) begin
      have_last = 1'b0; ack_seen = 1'b0;
    end else begin
      if (l1_flush_req && flush_ack) ack_seen = 1'b1;
      if (l1_pg_en) l1_seen = 1'b1;
      if (g != g_prev) begin
        chk($countones(g ^ g_prev) <= 1, "R4 one change", $countones(g ^ g_prev), 1);
        if (have_last) chk(cyc - last_chg >= step_delay + 1, "R4 spacing",
                           cyc - last_chg, step_delay + 1);
        last_chg = cyc; have_last = 1'b1;
        if (g[1] && !g_prev[1]) chk(ack_seen, "R3 gate before ack", 0, 1);
        if (g[3] && !g_prev[3]) chk(lock_prev, "R5 clock before lock", 0, 1);
        if (g[2] && !g_prev[2]) chk(!g[1] && !g[0], "R5 pll order", g[1:0], 0);
        if (!g[1] && g_prev[1]) chk(!g[0], "R5 l1 order", g[0], 0);
      end
      if (pm_state <= 3'd1) begin have_last = 1'b0; ack_seen = 1'b0; end
    end
    g_prev = g; lock_prev = pll_lock; cyc++;
  end

  task automatic do_reset();
    rst_n = 1'b0; sleep_req = 0; wake = 0; lf_req = 0; temp_hot = 0; rate_hot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_state(input int exp, input string req);
    int n = 0;
    while (pm_state != exp[2:0] && n < 600) begin @(negedge clk); n++; end
    chk(pm_state == exp[2:0], req, pm_state, exp);
  endtask

  task automatic enter(input int d);
    sleep_depth = d[1:0]; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk(pm_state == 3'd5, "R12 entering", pm_state, 5);
    wait_state(d + 1, "R2 sleep state");
    chk(clk_en == 0 && l1_pg_en == 1 && l1_flush_req == 0, "R2 clock/l1",
        {clk_en, l1_pg_en}, 1);
    chk(pll_en == (d == 1), "R2 pll", pll_en, d == 1);
    chk(core_pg_en == (d == 3), "R2 core gate", core_pg_en, d == 3);
  endtask

  task automatic leave(input int d);
    int n = 0;
    wake = 1'b1;
    while (n < 20000) begin
      @(negedge clk); n++; wake = 1'b0;
      if (n == 1) chk(pm_state == 3'd6, "R12 waking", pm_state, 6);
      if (wake_done) break;
    end
    chk(n - 1 == exp_lat(d), "R6 wake latency", n - 1, exp_lat(d));
    chk({clk_en, pll_en, l1_pg_en, core_pg_en} == 4'b1100 && pm_state == 3'd0,
        "R6 restored", {clk_en, pll_en, l1_pg_en, core_pg_en}, 4'b1100);
    @(negedge clk);
    chk(!wake_done, "R6 single pulse", wake_done, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk({clk_en, pll_en, l1_flush_req, l1_pg_en, core_pg_en} == 5'b11000, "R1 gates",
        {clk_en, pll_en, l1_flush_req, l1_pg_en, core_pg_en}, 5'b11000);
    chk(op_sel == 0 && wake_done == 0 && err == 0 && pm_state == 0, "R1 status",
        pm_state, 0);

    // directed: each depth, R2 R5 R6 R12
    for (int d = 1; d <= 3; d++) begin
      step_delay = 4'd2; ack_lat = 3;
      enter(d); leave(d);
    end

    // R7: wake during flush
    step_delay = 4'd1; ack_lat = 15; l1_seen = 1'b0;
    sleep_depth = 2'd3; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(l1_flush_req == 1, "R7 flush pending", l1_flush_req, 1);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    begin
      int n = 0;
      while (!wake_done && n < 200) begin @(negedge clk); n++; end
    end
    chk(wake_done == 1, "R7 done pulse", wake_done, 1);
    chk(l1_seen == 0, "R7 l1 never gated", l1_seen, 0);
    chk(clk_en == 1 && pll_en == 1 && core_pg_en == 0 && pm_state == 0,
        "R7 back to run", {clk_en, pll_en, core_pg_en}, 3'b110);

    // R8: illegal requests
    step_delay = 4'd0; ack_lat = 2;
    sleep_depth = 2'd0; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    @(negedge clk);
    chk(err == 1, "R8 depth zero sets err", err, 1);
    chk(pm_state == 0 && clk_en == 1 && l1_flush_req == 0, "R8 depth zero ignored",
        pm_state, 0);
    do_reset();
    chk(err == 0, "R8 err cleared by reset", err, 0);
    enter(2);
    sleep_depth = 2'd1; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(err == 1, "R8 request in sleep sets err", err, 1);
    chk(pm_state == 3'd3 && clk_en == 0 && pll_en == 0 && l1_pg_en == 1,
        "R8 sleep unchanged", pm_state, 3);
    leave(2);
    chk(err == 1, "R8 err sticky", err, 1);

    // R9 R10: throttle and hysteresis
    hyst_cnt = 8'd5;
    temp_hot = 1'b1; @(negedge clk); temp_hot = 1'b0;
    chk(op_sel == 1 && pm_state == 3'd1, "R9 temp throttle", op_sel, 1);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(op_sel == (k < 5), "R10 hysteresis", op_sel, k < 5);
    end
    rate_hot = 1'b1; @(negedge clk); rate_hot = 1'b0;
    chk(op_sel == 1, "R9 rate throttle", op_sel, 1);
    repeat (3) @(negedge clk);
    rate_hot = 1'b1; @(negedge clk); rate_hot = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(op_sel == (k < 5), "R10 restart", op_sel, k < 5);
    end
    hyst_cnt = 8'd0;
    temp_hot = 1'b1; @(negedge clk); temp_hot = 1'b0;
    @(negedge clk);
    chk(op_sel == 0, "R10 zero acts as one", op_sel, 0);

    // R11: voluntary low frequency
    lf_req = 1'b1; #1;
    chk(op_sel == 1 && pm_state == 3'd1, "R11 lf_req", pm_state, 1);
    @(negedge clk); lf_req = 1'b0; #1;
    chk(op_sel == 0 && pm_state == 3'd0, "R11 lf_req release", pm_state, 0);

    // random hysteresis lengths
    for (int i = 0; i < 4; i++) begin
      int h;
      h = $urandom_range(1, 20);
      hyst_cnt = h[7:0];
      rate_hot = 1'b1; repeat ($urandom_range(1, 4)) @(negedge clk); rate_hot = 1'b0;
      for (int k = 1; k <= h; k++) begin
        @(negedge clk);
        chk(op_sel == (k < h), "R10 random hysteresis", op_sel, k < h);
      end
    end

    // random sleep/wake sequences
    for (int i = 0; i < 10; i++) begin
      int d;
      d = $urandom_range(1, 3);
      step_delay = 4'($urandom_range(0, 7));
      ack_lat = $urandom_range(0, 6);
      repeat ($urandom_range(1, 5)) @(negedge clk);
      enter(d); leave(d);
    end

    finish_run();
  end
endmodule